// File: doc/BRIEF.md
# Programmable Audio Frame Sync Generator

This block paces a serial audio port. It runs on the bit clock. It splits the bit stream into fixed slots of 32 bit clocks and counts those slots with a programmable ratio to build frames. For each bit clock it drives three signals:

- a frame sync,
- the index of the current slot,
- a strobe on the first bit of every slot that carries a word.

It also drives a per-bit qualifier that marks which bits of a carried slot hold valid data. The data shifter that sits beside it uses these signals to move samples.

A single control word selects the operating mode, which is one of:

- **Single-word mode.** The ratio sets how many slot periods pass between carried words. One word is carried per frame.
- **Multi-slot mode.** The ratio is the number of slots in a frame, and every slot carries a word.
- **Two-channel stereo sub-mode.** The frame is forced to two slots.

Control changes are held back until the current frame ends. This means a frame is never cut short. All pins are plain level signals. There is no handshake, because the block produces timing and has no data stream.

Top module: `afs_frame_gen`

## Requirements
- R1: The divider field sits at `ctrl[12:8]`. A field value N gives a ratio of N+1 slot periods per frame. Each slot is 32 bit clocks. `slot_idx` counts 0 to ratio-1 and returns to 0 on the bit clock where `fsync` rises for the next frame.
- R2: In single-word mode (`ctrl[5]`=0, `ctrl[7:6]` neither 01 nor 10), only slot 0 carries a word. `word_start` pulses once per frame. `fsync` is exactly one bit clock wide, on the first bit of slot 0.
- R3: In single-word mode with field value 0, every slot period carries a word. `fsync` then pulses for one bit clock at the start of every slot.
- R4: In multi-slot mode (`ctrl[5]`=1), `word_start` pulses on the first bit of every slot. `fsync` stays high for all 32 bit clocks of slot 0.
- R5: In multi-slot mode, a field value of 0 is treated as a ratio of 2 and sets `cfg_err`. `cfg_err` then stays set until reset, whatever configuration follows.
- R6: When `ctrl[7:6]` is 01 or 10 (stereo master or stereo slave), the frame has two slots regardless of the divider field and of `ctrl[5]`. `fsync` covers slot 0 and `cfg_err` is not set.
- R7: `ctrl[4:0]` holds the number of valid bits minus one. `bit_valid` is high for that many leading bits of each slot that carries a word. The slot length stays 32 bit clocks.
- R8: A change on `ctrl` during a frame does not alter that frame. The new setting applies from the first bit clock of the next frame.
- R9: While `rst_n` is sampled low at a clock edge, the counters and `cfg_err` clear. All outputs read zero while `rst_n` is low. After release with `en` high, `fsync` is high on the very first bit clock.
- R10: While `en` is low, all pattern outputs read zero and the counters return to zero. Raising `en` again starts a fresh frame on that bit clock, using the `ctrl` value present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable |
| ctrl | input | 24 | Control word: [4:0] valid bits minus one, [5] multi-slot, [7:6] stereo select, [12:8] divider field, rest unused |
| fsync | output | 1 | Frame sync |
| word_start | output | 1 | First bit of a slot that carries a word |
| bit_valid | output | 1 | Current bit of a carried slot holds valid data |
| slot_idx | output | 5 | Slot index within the frame |
| cfg_err | output | 1 | Sticky flag for an illegal multi-slot ratio |

## Verification
The bench runs a fixed set of configurations, and each one separates a different part of the behaviour:

- Single-word mode with ratio 1 separates continuous transfer from gapped transfer.
- Single-word mode with ratios 4 and 32 shows one-bit sync pulses and single transfers per frame.
- Multi-slot mode with ratio 8 shows full-slot sync and a strobe in every slot.
- Multi-slot mode with field 0 separates the clamp from a plain N+1 decode.
- The two stereo codes, one with a conflicting divider and one with the multi-slot bit set, show that the two-slot override wins.

Word lengths vary across these runs so that the counts of valid bits tell the settings apart. Directed runs then cover the following:

- A ratio change made in mid-frame, which must wait for the frame boundary.
- The persistence of the error flag, and its clearing by reset.
- Restart after the enable is dropped.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int AFS_CTRL_W    = 24;
  localparam int AFS_SLOT_BITS = 32;
  localparam int AFS_DIV_LSB   = 8;
  localparam int AFS_DIV_W     = 5;
  localparam int AFS_NET_BIT   = 5;
  localparam int AFS_SEL_LSB   = 6;
  localparam int AFS_WL_W      = 5;

  localparam logic [1:0] SEL_MASTER = 2'b01;
  localparam logic [1:0] SEL_SLAVE  = 2'b10;

  function automatic logic is_stereo(input logic [1:0] sel);
    return (sel == SEL_MASTER) || (sel == SEL_SLAVE);
  endfunction
endpackage

// File: rtl/afs_cfg_decode.sv
module afs_cfg_decode
  import afs_pkg::*;
#(
  parameter int CTRL_W  = AFS_CTRL_W,
  parameter int DIV_LSB = AFS_DIV_LSB,
  parameter int DIV_W   = AFS_DIV_W,
  parameter int NET_BIT = AFS_NET_BIT,
  parameter int SEL_LSB = AFS_SEL_LSB,
  parameter int WL_W    = AFS_WL_W,
  localparam int RAT_W  = DIV_W + 1
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [RAT_W-1:0]  ratio,
  output logic              net,
  output logic [WL_W-1:0]   wl_m1,
  output logic              bad
);
  logic [DIV_W-1:0] field;
  logic [1:0]       sel;
  logic             unused_ctrl;

  assign field       = ctrl[DIV_LSB +: DIV_W];
  assign sel         = ctrl[SEL_LSB +: 2];
  assign wl_m1       = ctrl[WL_W-1:0];
  assign unused_ctrl = ^ctrl;

  always_comb begin
    ratio = RAT_W'(field) + RAT_W'(1);
    net   = 1'b0;
    bad   = 1'b0;
    if (is_stereo(sel)) begin
      // stereo selections force a two-slot frame
      ratio = RAT_W'(2);
      net   = 1'b1;
    end else if (ctrl[NET_BIT]) begin
      net = 1'b1;
      if (field == '0) begin
        // single-slot frame cannot exist in multi-slot mode: clamp
        ratio = RAT_W'(2);
        bad   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/afs_cfg_hold.sv
module afs_cfg_hold #(
  parameter int RAT_W = 6,
  parameter int WL_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RAT_W-1:0] nxt_ratio,
  input  logic             nxt_net,
  input  logic [WL_W-1:0]  nxt_wl,
  input  logic             nxt_bad,
  output logic [RAT_W-1:0] act_ratio,
  output logic             act_net,
  output logic [WL_W-1:0]  act_wl,
  output logic             cfg_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ratio <= RAT_W'(1);
      act_net   <= 1'b0;
      act_wl    <= '0;
      cfg_err   <= 1'b0;
    end else begin
      if (load) begin
        act_ratio <= nxt_ratio;
        act_net   <= nxt_net;
        act_wl    <= nxt_wl;
        if (nxt_bad) cfg_err <= 1'b1;
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R5
  AST_NET_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    act_net |-> (act_ratio >= RAT_W'(2))); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_ratio) && $stable(act_net) && $stable(act_wl))); // R8
endmodule

// File: rtl/afs_counters.sv
module afs_counters #(
  parameter int SLOT_BITS = 32,
  parameter int DIV_W     = 5,
  localparam int RAT_W    = DIV_W + 1,
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RAT_W-1:0] ratio,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [DIV_W-1:0] word_cnt,
  output logic             running,
  output logic             frame_end
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  logic slot_end;
  logic word_last;

  assign slot_end  = (bit_cnt == BIT_LAST);
  assign word_last = (RAT_W'(word_cnt) == (ratio - RAT_W'(1)));
  assign frame_end = slot_end && word_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
      running  <= 1'b0;
    end else begin
      running <= 1'b1;
      if (slot_end) begin
        bit_cnt  <= '0;
        word_cnt <= word_last ? '0 : word_cnt + DIV_W'(1);
      end else begin
        bit_cnt <= bit_cnt + BIT_W'(1);
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    RAT_W'(word_cnt) < ratio); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_end) |=> (bit_cnt == '0 && word_cnt == '0)); // R1
endmodule

// File: rtl/afs_outputs.sv
module afs_outputs #(
  parameter int DIV_W  = 5,
  parameter int BIT_W  = 5,
  parameter int WL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic [DIV_W-1:0] word_cnt,
  input  logic             net,
  input  logic [WL_W-1:0]  wl_m1,
  output logic             fsync,
  output logic             word_start,
  output logic             bit_valid,
  output logic [DIV_W-1:0] slot_idx
);
  logic live;
  logic carried;
  logic first_bit;
  logic first_slot;

  assign live       = en && rst_n;
  assign first_bit  = (bit_cnt == '0);
  assign first_slot = (word_cnt == '0);
  assign carried    = net || first_slot;

  assign fsync      = live && first_slot && (net || first_bit);
  assign word_start = live && carried && first_bit;
  assign bit_valid  = live && carried && (32'(bit_cnt) <= 32'(wl_m1));
  assign slot_idx   = live ? word_cnt : '0;

  AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !net && en) |=> !fsync); // R2
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> bit_valid); // R7
endmodule

// File: rtl/afs_frame_gen.sv
module afs_frame_gen
  import afs_pkg::*;
#(
  parameter int CTRL_W    = AFS_CTRL_W,
  parameter int SLOT_BITS = AFS_SLOT_BITS,
  parameter int DIV_LSB   = AFS_DIV_LSB,
  parameter int DIV_W     = AFS_DIV_W,
  parameter int NET_BIT   = AFS_NET_BIT,
  parameter int SEL_LSB   = AFS_SEL_LSB,
  parameter int WL_W      = AFS_WL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              fsync,
  output logic              word_start,
  output logic              bit_valid,
  output logic [DIV_W-1:0]  slot_idx,
  output logic              cfg_err
);
  localparam int RAT_W = DIV_W + 1;
  localparam int BIT_W = $clog2(SLOT_BITS);

  logic [RAT_W-1:0] nxt_ratio, act_ratio, eff_ratio;
  logic             nxt_net, act_net, eff_net, nxt_bad;
  logic [WL_W-1:0]  nxt_wl, act_wl, eff_wl;
  logic [BIT_W-1:0] bit_cnt;
  logic [DIV_W-1:0] word_cnt;
  logic             running, frame_end, load;

  afs_cfg_decode #(
    .CTRL_W(CTRL_W), .DIV_LSB(DIV_LSB), .DIV_W(DIV_W),
    .NET_BIT(NET_BIT), .SEL_LSB(SEL_LSB), .WL_W(WL_W)
  ) u_dec (
    .ctrl(ctrl), .ratio(nxt_ratio), .net(nxt_net), .wl_m1(nxt_wl), .bad(nxt_bad)
  );

  // a new setting is taken on the first clock of a run or at a frame boundary
  assign load = rst_n && en && (!running || frame_end);

  afs_cfg_hold #(.RAT_W(RAT_W), .WL_W(WL_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load),
    .nxt_ratio(nxt_ratio), .nxt_net(nxt_net), .nxt_wl(nxt_wl), .nxt_bad(nxt_bad),
    .act_ratio(act_ratio), .act_net(act_net), .act_wl(act_wl), .cfg_err(cfg_err)
  );

  // first bit clock of a run uses the live setting, later ones the held one
  assign eff_ratio = running ? act_ratio : nxt_ratio;
  assign eff_net   = running ? act_net   : nxt_net;
  assign eff_wl    = running ? act_wl    : nxt_wl;

  afs_counters #(.SLOT_BITS(SLOT_BITS), .DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .ratio(eff_ratio),
    .bit_cnt(bit_cnt), .word_cnt(word_cnt), .running(running), .frame_end(frame_end)
  );

  afs_outputs #(.DIV_W(DIV_W), .BIT_W(BIT_W), .WL_W(WL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_cnt(bit_cnt), .word_cnt(word_cnt),
    .net(eff_net), .wl_m1(eff_wl),
    .fsync(fsync), .word_start(word_start), .bit_valid(bit_valid), .slot_idx(slot_idx)
  );

  AST_STEREO_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (load && is_stereo(ctrl[SEL_LSB +: 2])) |=> (act_ratio == RAT_W'(2))); // R6
  AST_RUN_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> fsync); // R10
endmodule

// File: tb/afs_frame_gen_tb.sv
module afs_frame_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 32;

  typedef struct packed {
    logic [23:0] ctrl;
    int ratio;
    int fs_w;
    int ws_n;
    int valid_n;
    int err;
  } row_t;

  // ctrl bits: [4:0] wl-1, [5] multi-slot, [7:6] stereo sel, [12:8] divider
  localparam row_t ROWS [7] = '{
    '{24'h00000F,  1,  1, 1,  16, 0}, // R3 single-word, ratio 1, 16 bits
    '{24'h000317,  4,  1, 1,  24, 0}, // R2 single-word, ratio 4, 24 bits
    '{24'h00073F,  8, 32, 8, 256, 0}, // R4 multi-slot, 8 slots, 32 bits
    '{24'h000027,  2, 32, 2,  16, 1}, // R5 multi-slot field 0 clamps
    '{24'h00054F,  2, 32, 2,  32, 0}, // R6 stereo master, divider ignored
    '{24'h0000A0,  2, 32, 2,   2, 0}, // R6 stereo slave with multi-slot bit
    '{24'h001F04, 32,  1, 1,   5, 0}  // R7 single-word, ratio 32, 5 bits
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [23:0] ctrl = '0;
  logic        fsync, word_start, bit_valid, cfg_err;
  logic [4:0]  slot_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afs_frame_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl(ctrl),
    .fsync(fsync), .word_start(word_start), .bit_valid(bit_valid),
    .slot_idx(slot_idx), .cfg_err(cfg_err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9 reset state
    ctrl = 24'h00073F;
    en = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(fsync, 0, "R9 fsync in reset");
    chk(word_start, 0, "R9 word_start in reset");
    chk(bit_valid, 0, "R9 bit_valid in reset");
    chk(slot_idx, 0, "R9 slot_idx in reset");
    chk(cfg_err, 0, "R9 cfg_err in reset");

    // table walk
    for (int r = 0; r < 7; r++) begin
      int frame_len, fs_cnt, ws_cnt, v_cnt, max_slot;
      hold_reset();
      ctrl = ROWS[r].ctrl;
      en = 1'b1;
      rst_n = 1'b1;
      frame_len = ROWS[r].ratio * SLOT;
      fs_cnt = 0; ws_cnt = 0; v_cnt = 0; max_slot = 0;
      for (int k = 0; k <= frame_len; k++) begin
        #1;
        if (k == 0) chk(fsync, 1, $sformatf("R9 row%0d fsync on first clock", r));
        if (k < frame_len) begin
          fs_cnt += int'(fsync);
          ws_cnt += int'(word_start);
          v_cnt += int'(bit_valid);
          if (int'(slot_idx) > max_slot) max_slot = int'(slot_idx);
        end else begin
          chk(slot_idx, 0, $sformatf("R1 row%0d slot wraps", r));
          chk(fsync, 1, $sformatf("R1 row%0d fsync at next frame", r));
        end
        @(negedge clk);
      end
      chk(max_slot + 1, ROWS[r].ratio, $sformatf("R1 row%0d slots per frame", r));
      chk(fs_cnt, ROWS[r].fs_w, $sformatf("R2/R4 row%0d fsync width", r));
      chk(ws_cnt, ROWS[r].ws_n, $sformatf("R4 row%0d word starts", r));
      chk(v_cnt, ROWS[r].valid_n, $sformatf("R7 row%0d valid bits", r));
      chk(cfg_err, ROWS[r].err, $sformatf("R5/R6 row%0d cfg_err", r));
    end

    // R3 continuous transfer: pulse every slot, one bit wide
    hold_reset();
    ctrl = 24'h00000F;
    en = 1'b1;
    rst_n = 1'b1;
    for (int k = 0; k <= 65; k++) begin
      #1;
      if (k == 32 || k == 64) begin
        chk(fsync, 1, "R3 fsync each slot");
        chk(word_start, 1, "R3 word_start each slot");
      end
      if (k == 65) chk(fsync, 0, "R3 fsync one bit wide");
      @(negedge clk);
    end

    // R8 mid-frame ratio change waits for the boundary
    hold_reset();
    ctrl = 24'h000320;   // multi-slot, 4 slots
    en = 1'b1;
    rst_n = 1'b1;
    for (int k = 0; k <= 192; k++) begin
      #1;
      if (k == 96)  chk(slot_idx, 3, "R8 old ratio kept in frame");
      if (k == 128) chk(fsync, 1, "R8 boundary fsync");
      if (k == 160) chk(slot_idx, 1, "R8 new frame slot 1");
      if (k == 192) begin
        chk(slot_idx, 0, "R8 new ratio of 2 applied");
        chk(fsync, 1, "R8 new frame sync");
      end
      if (k == 40) ctrl = 24'h000120; // multi-slot, 2 slots
      @(negedge clk);
    end

    // R10 enable drop and restart
    en = 1'b0;
    #1;
    chk(fsync, 0, "R10 fsync with en low");
    chk(slot_idx, 0, "R10 slot_idx with en low");
    chk(bit_valid, 0, "R10 bit_valid with en low");
    repeat (5) @(negedge clk);
    ctrl = 24'h00000F;
    en = 1'b1;
    #1;
    chk(fsync, 1, "R10 restart fsync");
    chk(word_start, 1, "R10 restart word_start");
    @(negedge clk);
    #1;
    chk(fsync, 0, "R10 restart single-word sync width");

    // R5 sticky error, R9 reset clears it
    hold_reset();
    ctrl = 24'h000027;
    en = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    ctrl = 24'h00000F;
    repeat (130) @(negedge clk);
    #1;
    chk(cfg_err, 1, "R5 cfg_err stays set");
    chk(slot_idx, 0, "R5 legal setting now running");
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk(cfg_err, 0, "R9 reset clears cfg_err");
    chk(fsync, 0, "R9 fsync zero in reset");

    finish_run();
  end
endmodule